// File: doc/BRIEF.md
# Two-Bank Page Buffer Loader

The loader takes an already decoded write stream and fills one of two 256-byte page buffers. A load starts with a one-cycle command-start pulse. Two count cycles follow. After them come the data cycles, which carry the buffer address and the payload. The count gives the number of items to load, stored as the item count minus one. The item is a byte or a 16-bit word, chosen by the byte/word mode input at the moment the command starts. The high count byte must be zero. This limit keeps a load inside one 256-byte segment.

The first data cycle supplies the starting buffer address. Each later item goes to the next location, and the address wraps inside the buffer. In byte mode the address bit 0 of the first count cycle picks which count byte arrives first. The second count cycle always carries the other byte, whatever its address says. A swap command moves the load target to the other buffer. The loader drives one write-enable per buffer, a byte-lane enable, the buffer address and the data. It pulses load-complete with the last write. It raises an error flag when a command is rejected or a load is cut short.

Top module: `pbl_loader`

## Requirements
- R1: After reset, no buffer write-enable, load_done and load_err are all 0, and active_bank is 0.
- R2: A load with low count byte L performs exactly L+1 buffer writes. load_done is high in the same cycle as the last write and in no other cycle.
- R3: If the high count byte is nonzero, load_err goes to 1 in the cycle after the second count cycle and the loader returns to idle. No buffer write follows until a new command.
- R4: In word mode, the count bytes are taken from wr_data[7:0] and wr_data[15:8] is ignored. The first count cycle carries the low byte and the second carries the high byte.
- R5: In byte mode, wr_addr[0] of the first count cycle selects the order: 0 means the low count byte comes first, 1 means the high count byte comes first. The second count cycle supplies the other byte, and its wr_addr[0] is ignored.
- R6: Buffer writes come only from data cycles, which start with the fourth cycle of the sequence. Each write appears on the outputs one cycle after its data cycle is accepted.
- R7: The first data cycle writes at wr_addr. Each later item goes to the previous address plus 1 in byte mode, or plus 2 in word mode, modulo 256. wr_addr on later data cycles is ignored.
- R8: In word mode, buf_addr bit 0 is forced to 0, buf_be is 2'b11 and buf_data equals wr_data. In byte mode, buf_be is 2'b01 and buf_data is {8'h00, wr_data[7:0]}.
- R9: A swap_req while idle toggles active_bank. A load writes only into the bank that was active at its command start, using buf_we bit 0 for bank 0 and bit 1 for bank 1.
- R10: A swap_req while a load sequence is in progress has no effect on active_bank.
- R11: A cmd_start while a sequence is in progress aborts it, sets load_err, and begins a new sequence.
- R12: A cmd_start while idle clears load_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = byte items, 0 = word items; sampled at cmd_start |
| swap_req | input | 1 | Toggles the active bank when idle |
| cmd_start | input | 1 | One-cycle pulse that starts a load sequence |
| wr_valid | input | 1 | Marks a count or data cycle |
| wr_addr | input | 8 | Buffer byte address; bit 0 also orders the count bytes in byte mode |
| wr_data | input | 16 | Count byte (bits 7:0) or payload |
| buf_we | output | 2 | Per-bank write enable |
| buf_be | output | 2 | Byte-lane enable |
| buf_addr | output | 8 | Buffer byte address |
| buf_data | output | 16 | Buffer write data |
| load_done | output | 1 | Pulse with the last write of a load |
| load_err | output | 1 | Sticky error flag for a rejected or aborted load |
| active_bank | output | 1 | Bank that the next load will target |

## Verification
Word loads are run with a junk upper count byte, which would turn into a rejected high count if the loader read all sixteen bits. Byte loads are run with both count orders. The second count cycle carries an address bit that would flip the order if it were honoured. Start addresses near 0xFF and a full 256-byte load check that the address wraps and that the item count is right, so they catch off-by-one errors in both the count and the address step. Further sequences cover swap commands issued while idle and while busy, a nonzero high count, and a restart in the middle of a load. These show bank latching, rejection and abort, and each one leaves a different trace in the stream of writes and on the error flag.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CNT_A = 2'd1,
    ST_CNT_B = 2'd2,
    ST_DATA  = 2'd3
  } pbl_state_e;

  // True when the byte held from the first count cycle is the high count byte.
  function automatic logic held_is_high(input logic byte_md, input logic hi_first);
    return byte_md && hi_first;
  endfunction

endpackage

// File: rtl/pbl_seq.sv
module pbl_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          wr_valid,
  input  logic          byte_mode,
  input  logic          cnt_sel,
  input  logic [CW-1:0] cnt_byte,
  output logic          busy,
  output logic          mode_q,
  output logic          data_acc,
  output logic          data_first,
  output logic          data_last,
  output logic          bad_hi,
  output logic          abort,
  output logic          err
);
  import pbl_pkg::*;

  pbl_state_e    st_q, st_d;
  logic [CW-1:0] held_q;
  logic [CW-1:0] remain_q;
  logic [CW-1:0] hi_val;
  logic [CW-1:0] lo_val;
  logic          hi_first_q;
  logic          first_q;
  logic          err_q;
  logic          acc_a;
  logic          acc_b;

  assign busy       = (st_q != ST_IDLE);
  assign abort      = cmd_start && busy;
  assign acc_a      = (st_q == ST_CNT_A) && wr_valid && !cmd_start;
  assign acc_b      = (st_q == ST_CNT_B) && wr_valid && !cmd_start;
  assign data_acc   = (st_q == ST_DATA) && wr_valid && !cmd_start;
  assign data_first = first_q;
  assign data_last  = data_acc && (remain_q == '0);
  assign err        = err_q;

  always_comb begin
    if (held_is_high(mode_q, hi_first_q)) begin
      hi_val = held_q;
      lo_val = cnt_byte;
    end else begin
      hi_val = cnt_byte;
      lo_val = held_q;
    end
  end

  assign bad_hi = acc_b && (hi_val != '0);

  always_comb begin
    st_d = st_q;
    if (cmd_start) begin
      st_d = ST_CNT_A;
    end else begin
      unique case (st_q)
        ST_CNT_A: if (acc_a) st_d = ST_CNT_B;
        ST_CNT_B: if (acc_b) st_d = bad_hi ? ST_IDLE : ST_DATA;
        ST_DATA:  if (data_last) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      held_q     <= '0;
      remain_q   <= '0;
      hi_first_q <= 1'b0;
      first_q    <= 1'b0;
      mode_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cmd_start) begin
        mode_q <= byte_mode;
      end
      if (acc_a) begin
        held_q     <= cnt_byte;
        hi_first_q <= mode_q && cnt_sel;
      end
      if (acc_b && !bad_hi) begin
        remain_q <= lo_val;
        first_q  <= 1'b1;
      end else if (data_acc) begin
        remain_q <= remain_q - 1'b1;
        first_q  <= 1'b0;
      end
      if (cmd_start) begin
        err_q <= abort;
      end else if (bad_hi) begin
        err_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbl_addr_gen.sv
module pbl_addr_gen #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_q,
  input  logic          data_acc,
  input  logic          data_first,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] wa,
  output logic [DW/8-1:0] wbe,
  output logic [DW-1:0] wdata
);
  localparam int LANES = DW / 8;
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] base;

  function automatic logic [AW-1:0] align_addr(input logic [AW-1:0] a, input logic bm);
    logic [AW-1:0] m;
    m = ~((AW'(1) << LB) - AW'(1));
    return bm ? a : (a & m);
  endfunction

  function automatic logic [AW-1:0] addr_step(input logic bm);
    return bm ? AW'(1) : AW'(LANES);
  endfunction

  assign base  = data_first ? wr_addr : ptr_q;
  assign wa    = align_addr(base, mode_q);
  assign wbe   = mode_q ? {{(LANES-1){1'b0}}, 1'b1} : {LANES{1'b1}};
  assign wdata = mode_q ? {{(DW-8){1'b0}}, wr_data[7:0]} : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (data_acc) begin
      ptr_q <= wa + addr_step(mode_q);
    end
  end

endmodule

// File: rtl/pbl_bank_sel.sv
module pbl_bank_sel #(
  parameter int NBANK = 2,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_req,
  input  logic             busy,
  input  logic             cmd_start,
  input  logic             data_acc,
  output logic [BW-1:0]    active_q,
  output logic [NBANK-1:0] we_vec
);
  logic [BW-1:0] tgt_q;
  logic          swap_take;

  function automatic logic [BW-1:0] next_bank(input logic [BW-1:0] b);
    return (b == BW'(NBANK - 1)) ? '0 : b + 1'b1;
  endfunction

  assign swap_take = swap_req && !busy && !cmd_start;

  for (genvar g = 0; g < NBANK; g++) begin : g_we
    assign we_vec[g] = data_acc && (tgt_q == BW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      tgt_q    <= '0;
    end else begin
      if (swap_take) active_q <= next_bank(active_q);
      if (cmd_start) tgt_q <= active_q;
    end
  end

endmodule

// File: rtl/pbl_loader.sv
module pbl_loader #(
  parameter int NBANK     = 2,
  parameter int BUF_BYTES = 256,
  parameter int DW        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_mode,
  input  logic                       swap_req,
  input  logic                       cmd_start,
  input  logic                       wr_valid,
  input  logic [$clog2(BUF_BYTES)-1:0] wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic [NBANK-1:0]           buf_we,
  output logic [DW/8-1:0]            buf_be,
  output logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  output logic [DW-1:0]              buf_data,
  output logic                       load_done,
  output logic                       load_err,
  output logic [$clog2(NBANK)-1:0]   active_bank
);
  localparam int AW    = $clog2(BUF_BYTES);
  localparam int LANES = DW / 8;
  localparam int CW    = 8;

  logic             seq_busy;
  logic             seq_mode;
  logic             evt_data;
  logic             evt_first;
  logic             evt_last;
  logic             evt_bad_hi;
  logic             evt_abort;
  logic [AW-1:0]    gen_addr;
  logic [LANES-1:0] gen_be;
  logic [DW-1:0]    gen_data;
  logic [NBANK-1:0] gen_we;

  pbl_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .wr_valid   (wr_valid),
    .byte_mode  (byte_mode),
    .cnt_sel    (wr_addr[0]),
    .cnt_byte   (wr_data[CW-1:0]),
    .busy       (seq_busy),
    .mode_q     (seq_mode),
    .data_acc   (evt_data),
    .data_first (evt_first),
    .data_last  (evt_last),
    .bad_hi     (evt_bad_hi),
    .abort      (evt_abort),
    .err        (load_err)
  );

  pbl_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (seq_mode),
    .data_acc   (evt_data),
    .data_first (evt_first),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wa         (gen_addr),
    .wbe        (gen_be),
    .wdata      (gen_data)
  );

  pbl_bank_sel #(.NBANK(NBANK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .busy      (seq_busy),
    .cmd_start (cmd_start),
    .data_acc  (evt_data),
    .active_q  (active_bank),
    .we_vec    (gen_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_we    <= '0;
      buf_be    <= '0;
      buf_addr  <= '0;
      buf_data  <= '0;
      load_done <= 1'b0;
    end else begin
      buf_we    <= gen_we;
      load_done <= evt_last;
      if (evt_data) begin
        buf_be   <= gen_be;
        buf_addr <= gen_addr;
        buf_data <= gen_data;
      end
    end
  end

endmodule

// File: rtl/pbl_loader_chk.sv
module pbl_loader_chk #(
  parameter int NBANK = 2,
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_start,
  input logic                     swap_req,
  input logic                     busy,
  input logic                     bad_hi,
  input logic [NBANK-1:0]         buf_we,
  input logic [LANES-1:0]         buf_be,
  input logic [AW-1:0]            buf_addr,
  input logic                     load_done,
  input logic                     load_err,
  input logic [$clog2(NBANK)-1:0] active_bank
);

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_we)); // R9

  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (|buf_we)); // R2

  AST_NO_WRITE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (buf_we == '0)); // R6

  AST_BAD_HIGH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_hi |=> (load_err && !busy)); // R3

  AST_SWAP_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && swap_req) |=> $stable(active_bank)); // R10

  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start) |=> (load_err && busy)); // R11

  AST_IDLE_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start) |=> !load_err); // R12

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ((|buf_we) && (buf_be == {LANES{1'b1}})) |-> !buf_addr[0]); // R8

endmodule

bind pbl_loader pbl_loader_chk #(
  .NBANK (NBANK),
  .AW    (AW),
  .LANES (LANES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_start   (cmd_start),
  .swap_req    (swap_req),
  .busy        (seq_busy),
  .bad_hi      (evt_bad_hi),
  .buf_we      (buf_we),
  .buf_be      (buf_be),
  .buf_addr    (buf_addr),
  .load_done   (load_done),
  .load_err    (load_err),
  .active_bank (active_bank)
);

// File: tb/pbl_loader_bench.sv
`timescale 1ns/1ps
module pbl_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic        swap_req = 1'b0;
  logic        cmd_start = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  buf_we;
  logic [1:0]  buf_be;
  logic [7:0]  buf_addr;
  logic [15:0] buf_data;
  logic        load_done;
  logic        load_err;
  logic [0:0]  active_bank;

  always #2.5 clk = ~clk;

  pbl_loader u_pbl_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_mode   (byte_mode),
    .swap_req    (swap_req),
    .cmd_start   (cmd_start),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .buf_we      (buf_we),
    .buf_be      (buf_be),
    .buf_addr    (buf_addr),
    .buf_data    (buf_data),
    .load_done   (load_done),
    .load_err    (load_err),
    .active_bank (active_bank)
  );

  typedef struct packed {
    logic        bank;
    logic [1:0]  be;
    logic [7:0]  addr;
    logic [15:0] data;
    logic        done;
  } exp_t;

  exp_t exp_q[$];
  int   compared = 0;
  int   mismatched = 0;
  int   writes = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard for every buffer write it sees.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (|buf_we) begin
        exp_t got;
        writes++;
        got = '{bank: buf_we[1], be: buf_be, addr: buf_addr, data: buf_data, done: load_done};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 write with nothing expected", 32'(got), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(got == e, "R2/R7/R8/R9 write {bank,be,addr,data,done}", 32'(got), 32'(e));
        end
      end else if (load_done) begin
        chk(1'b0, "R2 load_done without write", 32'(load_done), 32'h0);
      end
    end
  end

  task automatic cyc_cmd();
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic cyc_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  task automatic cyc_wr(input logic [7:0] a, input logic [15:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_addr  = 8'hA7;
    wr_data  = 16'hDEAD;
  endtask

  // Driver: runs one load sequence and pushes the writes it should produce.
  task automatic do_load(input bit bm, input int n, input logic [7:0] start, input bit hf,
                         input logic [15:0] base, input bit bank, input int stop_after,
                         input bit swap_mid);
    logic [7:0] lo;
    int         items;
    lo = 8'(n - 1);
    items = (stop_after > 0) ? stop_after : n;
    byte_mode = bm;
    cyc_cmd();
    if (swap_mid) cyc_swap();
    if (bm) begin
      if (hf) begin
        cyc_wr(8'h01, {8'hC3, 8'h00});
        cyc_wr(8'h01, {8'hC3, lo});
      end else begin
        cyc_wr(8'h00, {8'h3C, lo});
        cyc_wr(8'h00, {8'h3C, 8'h00});
      end
    end else begin
      cyc_wr(8'h00, {8'hFF, lo});
      cyc_wr(8'h00, {8'hEE, 8'h00});
    end
    for (int i = 0; i < items; i++) begin
      exp_t e;
      logic [15:0] d;
      d = base + 16'(i) * 16'h0103;
      e.bank = bank;
      e.done = (stop_after == 0) && (i == n - 1);
      if (bm) begin
        e.addr = start + 8'(i);
        e.be   = 2'b01;
        e.data = {8'h00, d[7:0]};
      end else begin
        e.addr = {start[7:1], 1'b0} + 8'(2 * i);
        e.be   = 2'b11;
        e.data = d;
      end
      exp_q.push_back(e);
      cyc_wr((i == 0) ? start : 8'h5B, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(exp_q.size()), 32'h0);
    finish_up();
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(buf_we == 2'b00, "R1 buf_we after reset", 32'(buf_we), 32'h0);
    chk(load_done == 1'b0, "R1 load_done after reset", 32'(load_done), 32'h0);
    chk(load_err == 1'b0, "R1 load_err after reset", 32'(load_err), 32'h0);
    chk(active_bank == 1'b0, "R1 active_bank after reset", 32'(active_bank), 32'h0);

    // R4 word load; the junk upper count byte must be ignored
    w0 = writes;
    do_load(1'b0, 4, 8'h10, 1'b0, 16'h1200, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk(writes - w0 == 4, "R2 R4 word load write count", 32'(writes - w0), 32'd4);
    chk(load_err == 1'b0, "R4 no error on word count", 32'(load_err), 32'h0);

    // R5 byte mode, low count byte first, with address wrap
    w0 = writes;
    do_load(1'b1, 3, 8'hFE, 1'b0, 16'h0041, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk(writes - w0 == 3, "R5 R7 byte lo-first count", 32'(writes - w0), 32'd3);

    // R5 byte mode, high count byte first
    w0 = writes;
    do_load(1'b1, 2, 8'h40, 1'b1, 16'h0090, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk(writes - w0 == 2, "R5 byte hi-first count", 32'(writes - w0), 32'd2);
    chk(load_err == 1'b0, "R5 no error hi-first", 32'(load_err), 32'h0);

    // R2 count 00 gives one word; R8 odd start aligned
    w0 = writes;
    do_load(1'b0, 1, 8'h21, 1'b0, 16'hBEEF, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk(writes - w0 == 1, "R2 single item", 32'(writes - w0), 32'd1);

    // R7 word wrap
    do_load(1'b0, 3, 8'hFC, 1'b0, 16'h7000, 1'b0, 0, 1'b0);
    @(negedge clk);

    // R9 swap while idle, then load into bank 1
    cyc_swap();
    chk(active_bank == 1'b1, "R9 swap toggles bank", 32'(active_bank), 32'h1);
    do_load(1'b0, 2, 8'h80, 1'b0, 16'h3300, 1'b1, 0, 1'b0);
    @(negedge clk);

    // R10 swap during a sequence ignored
    do_load(1'b1, 2, 8'h08, 1'b0, 16'h0011, 1'b1, 0, 1'b1);
    @(negedge clk);
    chk(active_bank == 1'b1, "R10 swap while busy ignored", 32'(active_bank), 32'h1);

    // R3 nonzero high count rejected
    w0 = writes;
    byte_mode = 1'b0;
    cyc_cmd();
    cyc_wr(8'h00, 16'h0003);
    cyc_wr(8'h00, 16'h0001);
    chk(load_err == 1'b1, "R3 high count sets error", 32'(load_err), 32'h1);
    cyc_wr(8'h10, 16'h1111);
    cyc_wr(8'h12, 16'h2222);
    cyc_wr(8'h14, 16'h3333);
    @(negedge clk);
    chk(writes - w0 == 0, "R3 no writes after rejection", 32'(writes - w0), 32'd0);

    // R12 idle command clears the flag
    cyc_cmd();
    chk(load_err == 1'b0, "R12 idle start clears error", 32'(load_err), 32'h0);
    cyc_wr(8'h00, 16'h0000);
    cyc_wr(8'h00, 16'h0000);
    exp_q.push_back('{bank: 1'b1, be: 2'b11, addr: 8'h30, data: 16'h4242, done: 1'b1});
    cyc_wr(8'h30, 16'h4242);
    @(negedge clk);

    // R11 abort mid-load, then a complete restart
    w0 = writes;
    do_load(1'b0, 5, 8'h50, 1'b0, 16'h5000, 1'b1, 2, 1'b0);
    do_load(1'b0, 2, 8'h60, 1'b0, 16'h6000, 1'b1, 0, 1'b0);
    @(negedge clk);
    chk(load_err == 1'b1, "R11 abort sets error", 32'(load_err), 32'h1);
    chk(writes - w0 == 4, "R11 writes across abort", 32'(writes - w0), 32'd4);

    // R2 R7 full 256-byte load into bank 0
    cyc_swap();
    w0 = writes;
    do_load(1'b1, 256, 8'h80, 1'b0, 16'h0000, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk(writes - w0 == 256, "R2 full buffer count", 32'(writes - w0), 32'd256);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_up();
  end

endmodule